// File: doc/BRIEF.md
# Unaligned Access Transfer Splitter

This block connects a load/store unit to a 32-bit data bus. It accepts one memory operand request at a time. Each request carries a byte address, a size code for 1, 2, 4 or 8 bytes, a read/write flag and right-justified write data. The block turns the request into the shortest run of naturally aligned bus beats. No beat crosses a 32-bit word boundary, and each beat carries a word address and a 4-bit byte-enable mask.

For reads, the bytes that come back on each accepted beat are packed into one right-justified result. A one-cycle done strobe then presents that result. Writes end with the same strobe. Both sides use a valid/ready handshake. The request side stays closed until the whole sequence is finished.

Byte numbering is big-endian. Bus lane `l` holds the byte at word offset `l`, carried on bus bits `[31-8l : 24-8l]` and enabled by byte-enable bit `3-l`. Operand byte `k`, where byte 0 is the most significant byte of the right-justified value, lives at address `addr+k`.

Top module: `usplit_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, and `bus_valid` and `done_valid` are 0.
- R2: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. An operand of up to 4 bytes whose address is a multiple of its size completes in exactly one bus beat.
- R3: The number of beats equals the number of distinct 4-byte words the operand touches. An aligned 8-byte operand takes 2 beats, a 4-byte operand at a non-zero word offset takes 2, and an 8-byte operand at a non-zero word offset takes 3.
- R4: `bus_addr` is a word address with its two low bits zero. Beats go in ascending word order. The first beat is offered in the cycle right after the request is accepted.
- R5: In each beat, byte-enable bit `3-l` is set exactly for the lanes `l` holding operand bytes, lane `l` being word offset `l`.
- R6: On writes, operand byte `k` appears on the lane of address `addr+k`. Lanes that are not enabled carry zero. Bits of `req_wdata` above the operand size have no effect.
- R7: On reads, `done_rdata` holds the operand bytes right-justified, with byte 0 most significant and zeros above the operand. Read data on lanes that are not enabled has no effect.
- R8: `done_valid` pulses for exactly one cycle, in the cycle after the last beat is accepted. `bus_valid` is 0 in that cycle.
- R9: `req_ready` is 0 from the cycle after acceptance until the done cycle. A `req_valid` raised during that time starts nothing and does not disturb the beats in progress.
- R10: While `bus_valid` is 1 and `bus_ready` is 0, the beat stays offered with `bus_addr`, `bus_be`, `bus_wdata` and `bus_write` unchanged.
- R11: `bus_write` equals the request's write flag on every beat. For writes, `done_rdata` is zero at the done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Splitter idle, can take a request |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Size code (0:1, 1:2, 2:4, 3:8 bytes) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 64 | Right-justified write operand |
| bus_valid | output | 1 | Beat offered on the bus |
| bus_ready | input | 1 | Bus accepts the beat; read data valid |
| bus_addr | output | ADDR_W | Word address of the beat |
| bus_be | output | 4 | Byte enables, bit 3-l for lane l |
| bus_write | output | 1 | Beat direction |
| bus_wdata | output | 32 | Write data lanes |
| bus_rdata | input | 32 | Read data lanes, sampled on acceptance |
| done_valid | output | 1 | One-cycle completion strobe |
| done_rdata | output | 64 | Right-justified read result |

## Verification
Directed requests first place each size at every word offset that matters. These runs separate one-beat, two-beat and three-beat splits and show whether the lane masks and data placement line up. An 8-byte operand at offset 4 separates a word-granular split from one keyed to 8-byte alignment. An address just below the top of the address space shows that the word address wraps correctly.

Seeded random requests then mix sizes, offsets and directions, with random bus stalls, junk data on lanes that are not enabled, junk upper write bits, and junk requests raised while busy. These runs expose any leak of stray bytes into the result, any beat that changes under a stall, and any request that is taken while the block is busy.

// File: rtl/usplit_pkg.sv
package usplit_pkg;

   typedef enum logic {
      US_IDLE = 1'b0,
      US_RUN  = 1'b1
   } us_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/usplit_lane_plan.sv
module usplit_lane_plan #(
   parameter int unsigned BUS_BYTES = 4,
   parameter int unsigned CNT_W     = 4,
   localparam int unsigned LANE_W   = $clog2(BUS_BYTES)
) (
   input  logic [LANE_W-1:0]    lane,
   input  logic [CNT_W-1:0]     left,
   output logic [CNT_W-1:0]     take,
   output logic [BUS_BYTES-1:0] be,
   output logic                 last
);

   logic [CNT_W-1:0] room;
   logic [CNT_W:0]   lo_lane;
   logic [CNT_W:0]   hi_lane;

   // bytes left in the current word from this lane on
   assign room    = CNT_W'(BUS_BYTES) - CNT_W'(lane);
   assign last    = (left <= room);
   assign take    = last ? left : room;
   assign lo_lane = (CNT_W+1)'(lane);
   assign hi_lane = (CNT_W+1)'(lane) + (CNT_W+1)'(take);

   for (genvar l = 0; l < BUS_BYTES; l++) begin : g_lane
      assign be[BUS_BYTES-1-l] = ((CNT_W+1)'(l) >= lo_lane) &&
                                 ((CNT_W+1)'(l) <  hi_lane);
   end

endmodule

// File: rtl/usplit_wsteer.sv
module usplit_wsteer #(
   parameter int unsigned BUS_BYTES = 4,
   localparam int unsigned BUS_W    = 8 * BUS_BYTES,
   localparam int unsigned LANE_W   = $clog2(BUS_BYTES)
) (
   input  logic [BUS_W-1:0]     head,
   input  logic [LANE_W-1:0]    lane,
   input  logic [BUS_BYTES-1:0] be,
   output logic [BUS_W-1:0]     wdata
);

   logic [BUS_W-1:0] placed;

   // head byte 0 (most significant) moves to the starting lane
   assign placed = head >> {lane, 3'b000};

   for (genvar l = 0; l < BUS_BYTES; l++) begin : g_mask
      assign wdata[8*(BUS_BYTES-1-l) +: 8] =
         be[BUS_BYTES-1-l] ? placed[8*(BUS_BYTES-1-l) +: 8] : 8'h00;
   end

endmodule

// File: rtl/usplit_rgather.sv
module usplit_rgather #(
   parameter int unsigned BUS_BYTES = 4,
   parameter int unsigned MAX_BYTES = 8,
   parameter int unsigned CNT_W     = 4,
   localparam int unsigned BUS_W    = 8 * BUS_BYTES,
   localparam int unsigned OP_W     = 8 * MAX_BYTES,
   localparam int unsigned LANE_W   = $clog2(BUS_BYTES)
) (
   input  logic [LANE_W-1:0] lane,
   input  logic [CNT_W-1:0]  take,
   input  logic [BUS_W-1:0]  rdata,
   input  logic [OP_W-1:0]   acc,
   output logic [OP_W-1:0]   acc_next
);

   logic [BUS_W-1:0] dropped;
   logic [BUS_W-1:0] fresh;
   logic [CNT_W-1:0] spare;

   // discard lanes before the start, then right-justify the taken bytes
   assign dropped  = rdata << {lane, 3'b000};
   assign spare    = CNT_W'(BUS_BYTES) - take;
   assign fresh    = dropped >> {spare, 3'b000};
   assign acc_next = (acc << {take, 3'b000}) | OP_W'(fresh);

endmodule

// File: rtl/usplit_top.sv
module usplit_top
   import usplit_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned BUS_BYTES = 4,
   parameter int unsigned MAX_BYTES = 8,
   localparam int unsigned BUS_W    = 8 * BUS_BYTES,
   localparam int unsigned OP_W     = 8 * MAX_BYTES,
   localparam int unsigned SIZE_W   = $clog2($clog2(MAX_BYTES) + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [SIZE_W-1:0]    req_size,
   input  logic                 req_write,
   input  logic [OP_W-1:0]      req_wdata,
   output logic                 bus_valid,
   input  logic                 bus_ready,
   output logic [ADDR_W-1:0]    bus_addr,
   output logic [BUS_BYTES-1:0] bus_be,
   output logic                 bus_write,
   output logic [BUS_W-1:0]     bus_wdata,
   input  logic [BUS_W-1:0]     bus_rdata,
   output logic                 done_valid,
   output logic [OP_W-1:0]      done_rdata
);

   localparam int unsigned LANE_W = $clog2(BUS_BYTES);
   localparam int unsigned CNT_W  = $clog2(MAX_BYTES + 1);
   localparam int unsigned WORD_W = ADDR_W - LANE_W;

   // elaboration-time parameter checks
   if (!is_pow2(BUS_BYTES) || BUS_BYTES < 2) begin : g_bad_bus
      $error("usplit_top: BUS_BYTES must be a power of two of at least 2");
   end
   if (!is_pow2(MAX_BYTES) || MAX_BYTES < BUS_BYTES) begin : g_bad_max
      $error("usplit_top: MAX_BYTES must be a power of two not below BUS_BYTES");
   end
   if (ADDR_W <= LANE_W) begin : g_bad_addr
      $error("usplit_top: ADDR_W too small for the bus width");
   end

   us_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0] left_q;
   logic [OP_W-1:0]  wsh_q;
   logic [OP_W-1:0]  acc_q;
   logic [OP_W-1:0]  result_q;
   logic             wr_q;
   logic             done_q;

   logic [LANE_W-1:0]    lane;
   logic [CNT_W-1:0]     take;
   logic [BUS_BYTES-1:0] be;
   logic                 beat_last;
   logic [OP_W-1:0]      acc_next;
   logic [CNT_W-1:0]     req_bytes;
   logic [CNT_W-1:0]     req_pad;
   logic [WORD_W-1:0]    word_next;
   logic                 accept_req;
   logic                 beat_fire;

   assign lane       = addr_q[LANE_W-1:0];
   assign req_ready  = (state_q == US_IDLE);
   assign bus_valid  = (state_q == US_RUN);
   assign accept_req = req_valid && req_ready;
   assign beat_fire  = bus_valid && bus_ready;
   assign req_bytes  = CNT_W'(1) << req_size;
   assign req_pad    = CNT_W'(MAX_BYTES) - req_bytes;
   assign word_next  = addr_q[ADDR_W-1:LANE_W] + WORD_W'(1);

   assign bus_addr   = {addr_q[ADDR_W-1:LANE_W], LANE_W'(0)};
   assign bus_be     = be;
   assign bus_write  = wr_q;
   assign done_valid = done_q;
   assign done_rdata = result_q;

   usplit_lane_plan #(
      .BUS_BYTES (BUS_BYTES),
      .CNT_W     (CNT_W)
   ) u_plan (
      .lane (lane),
      .left (left_q),
      .take (take),
      .be   (be),
      .last (beat_last)
   );

   usplit_wsteer #(
      .BUS_BYTES (BUS_BYTES)
   ) u_wsteer (
      .head  (wsh_q[OP_W-1 -: BUS_W]),
      .lane  (lane),
      .be    (be),
      .wdata (bus_wdata)
   );

   usplit_rgather #(
      .BUS_BYTES (BUS_BYTES),
      .MAX_BYTES (MAX_BYTES),
      .CNT_W     (CNT_W)
   ) u_gather (
      .lane     (lane),
      .take     (take),
      .rdata    (bus_rdata),
      .acc      (acc_q),
      .acc_next (acc_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= US_IDLE;
         addr_q   <= '0;
         left_q   <= '0;
         wsh_q    <= '0;
         acc_q    <= '0;
         result_q <= '0;
         wr_q     <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            US_IDLE: begin
               if (accept_req) begin
                  addr_q  <= req_addr;
                  left_q  <= req_bytes;
                  // left-justify the operand; bits above its size fall off
                  wsh_q   <= req_wdata << {req_pad, 3'b000};
                  acc_q   <= '0;
                  wr_q    <= req_write;
                  state_q <= US_RUN;
               end
            end
            US_RUN: begin
               if (beat_fire) begin
                  addr_q <= {word_next, LANE_W'(0)};
                  left_q <= left_q - take;
                  wsh_q  <= wsh_q << {take, 3'b000};
                  acc_q  <= acc_next;
                  if (beat_last) begin
                     state_q  <= US_IDLE;
                     done_q   <= 1'b1;
                     result_q <= wr_q ? '0 : acc_next;
                  end
               end
            end
            default: state_q <= US_IDLE;
         endcase
      end
   end

   // R10: a stalled beat is held unchanged
   a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
      $stable(bus_be) && $stable(bus_wdata) && $stable(bus_write));

   // R9: no request is taken while beats are pending
   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> !req_ready);

   // R8: completion strobe is a single cycle
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   // R8: strobe follows the last accepted beat
   a_r8_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_ready && beat_last |=> done_valid && !bus_valid);

   // R4: a non-final beat is followed by the next word
   a_r4_next_word: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_ready && !beat_last |=>
      bus_valid && (bus_addr == $past(bus_addr) + ADDR_W'(BUS_BYTES)));

   // R5: every offered beat enables at least one lane
   a_r5_be_present: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_be != '0));

endmodule

// File: tb/tb_usplit_top.sv
module tb_usplit_top;

   localparam int CLK_NS = 10;

   logic        clk;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_addr;
   logic [1:0]  req_size;
   logic        req_write;
   logic [63:0] req_wdata;
   logic        bus_valid;
   logic        bus_ready;
   logic [31:0] bus_addr;
   logic [3:0]  bus_be;
   logic        bus_write;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        done_valid;
   logic [63:0] done_rdata;

   int checks = 0;
   int errors = 0;

   usplit_top dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .req_size   (req_size),
      .req_write  (req_write),
      .req_wdata  (req_wdata),
      .bus_valid  (bus_valid),
      .bus_ready  (bus_ready),
      .bus_addr   (bus_addr),
      .bus_be     (bus_be),
      .bus_write  (bus_write),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .done_valid (done_valid),
      .done_rdata (done_rdata)
   );

   initial clk = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] memb(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   task automatic run_req(input logic [31:0] addr, input logic [1:0] size,
                          input logic wr, input logic [63:0] wdata,
                          input int stall_pct);
      logic [31:0] eaddr [4];
      logic [3:0]  ebe   [4];
      logic [31:0] ewd   [4];
      logic [63:0] er;
      logic [31:0] cur;
      int nb, n, k, lane, cnt, beat, cyc;
      bit got;
      n = 1 << size;
      nb = 0; er = '0; k = 0; cur = addr;
      while (k < n) begin
         lane = int'(cur[1:0]);
         cnt = 4 - lane;
         if (n - k < cnt) cnt = n - k;
         eaddr[nb] = {cur[31:2], 2'b00};
         ebe[nb] = '0;
         ewd[nb] = '0;
         for (int j = 0; j < cnt; j++) begin
            ebe[nb][3-(lane+j)] = 1'b1;
            ewd[nb][8*(3-(lane+j)) +: 8] = wdata[8*(n-1-(k+j)) +: 8];
            er = {er[55:0], memb(cur + 32'(j))};
         end
         nb++;
         k += cnt;
         cur = cur + 32'(cnt);
      end
      if (wr) er = '0;
      // upper request bits beyond the operand get junk (R6: must be ignored)
      @(negedge clk);
      check(req_ready == 1'b1, "R9 ready when idle", 64'(req_ready), 64'd1);
      req_valid = 1'b1;
      req_addr  = addr;
      req_size  = size;
      req_write = wr;
      req_wdata = (n == 8) ? wdata : (wdata | ({$urandom, $urandom} << (8*n)));
      beat = 0; got = 0; cyc = 0;
      while (!got && cyc < 64) begin
         @(negedge clk);
         cyc++;
         // junk requests while busy (R9: must be ignored)
         req_valid = bus_valid ? 1'($urandom % 2) : 1'b0;
         req_addr  = $urandom;
         req_size  = 2'($urandom);
         req_write = 1'($urandom);
         req_wdata = {$urandom, $urandom};
         if (cyc == 1)
            check(bus_valid == 1'b1, "R4 first beat right after accept",
                  64'(bus_valid), 64'd1);
         if (done_valid) begin
            got = 1;
            check(beat == nb, "R3 beat count", 64'(beat), 64'(nb));
            if (wr)
               check(done_rdata == 64'd0, "R11 write result zero", done_rdata, 64'd0);
            else
               check(done_rdata == er, "R7 read result", done_rdata, er);
            check(bus_valid == 1'b0, "R8 bus idle at done", 64'(bus_valid), 64'd0);
            check(req_ready == 1'b1, "R9 ready at done", 64'(req_ready), 64'd1);
            bus_ready = 1'b0;
         end else begin
            check(req_ready == 1'b0, "R9 ready low while busy", 64'(req_ready), 64'd0);
            if (bus_valid) begin
               if (beat < nb) begin
                  check(bus_addr == eaddr[beat], "R4 beat address",
                        64'(bus_addr), 64'(eaddr[beat]));
                  check(bus_be == ebe[beat], "R5 byte enables",
                        64'(bus_be), 64'(ebe[beat]));
                  check(bus_write == wr, "R11 bus direction",
                        64'(bus_write), 64'(wr));
                  if (wr)
                     check(bus_wdata == ewd[beat], "R6 write lanes",
                           64'(bus_wdata), 64'(ewd[beat]));
               end else begin
                  check(1'b0, "R3 extra beat", 64'(beat), 64'(nb));
               end
               bus_ready = (int'($urandom % 100) >= stall_pct);
               for (int l = 0; l < 4; l++)
                  bus_rdata[8*(3-l) +: 8] = bus_be[3-l] ?
                     memb(bus_addr + 32'(l)) : 8'($urandom);
               if (bus_ready) beat++;
            end else begin
               bus_ready = 1'b0;
            end
         end
      end
      if (!got) check(1'b0, "R8 done never seen", 64'(beat), 64'(nb));
      req_valid = 1'b0;
      bus_ready = 1'b0;
      @(negedge clk);
      check(done_valid == 1'b0, "R8 single-cycle strobe", 64'(done_valid), 64'd0);
   endtask

   initial begin
      #(CLK_NS * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
      req_write = 1'b0; req_wdata = '0; bus_ready = 1'b0; bus_rdata = '0;
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
      check(bus_valid == 1'b0, "R1 reset bus idle", 64'(bus_valid), 64'd0);
      check(done_valid == 1'b0, "R1 reset no done", 64'(done_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && bus_valid == 1'b0 && done_valid == 1'b0,
            "R1 after reset", {61'd0, req_ready, bus_valid, done_valid}, 64'd4);

      // R2: aligned sizes up to 4 bytes, one beat each
      for (int s = 0; s < 3; s++) begin
         run_req(32'h100, 2'(s), 1'b0, 64'h0, 0);
         run_req(32'h200 + 32'(1 << s), 2'(s), 1'b1, 64'h1122334455667788, 0);
      end
      // R3: aligned and word-offset 8-byte, unaligned 4-byte and 2-byte
      run_req(32'h100, 2'd3, 1'b0, 64'h0, 0);
      run_req(32'h108, 2'd3, 1'b1, 64'hA1B2C3D4E5F60718, 30);
      run_req(32'h104, 2'd3, 1'b0, 64'h0, 30);
      run_req(32'h105, 2'd3, 1'b1, 64'h0102030405060708, 30);
      run_req(32'h107, 2'd3, 1'b0, 64'h0, 50);
      run_req(32'h101, 2'd2, 1'b1, 64'hDEADBEEF, 0);
      run_req(32'h102, 2'd2, 1'b0, 64'h0, 0);
      run_req(32'h103, 2'd2, 1'b1, 64'hCAFEF00D, 50);
      run_req(32'h103, 2'd1, 1'b0, 64'h0, 0);
      run_req(32'h103, 2'd1, 1'b1, 64'h0000BEEF, 0);
      // R4: word address wraps at the top of the address space
      run_req(32'hFFFF_FFFE, 2'd2, 1'b0, 64'h0, 0);
      run_req(32'hFFFF_FFFD, 2'd3, 1'b1, 64'h8877665544332211, 20);

      for (int i = 0; i < 400; i++)
         run_req($urandom, 2'($urandom), 1'($urandom),
                 {$urandom, $urandom}, int'($urandom % 60));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule